// File: doc/BRIEF.md
# Programmable interrupt level arbiter

The arbiter sits between twelve peripheral interrupt request lines and a small CPU core. Each request line owns a 2-bit level code that software writes through a byte-wide bus. Four codes share a byte, so three consecutive register addresses hold all twelve codes. The registers can only be written. A read of any of those addresses returns all ones.

Every clock, the block decodes each source's code into a priority level. A request qualifies only when its level is numerically below the CPU's current interrupt level. Among the qualifying requests, the highest-priority one is chosen. The block then registers three outputs: an accept flag, the winning source number and the winner's decoded level. The CPU uses that level to raise its own level when it enters the handler.

Output sequencing uses a two-state machine:
- ST_IDLE: no request qualified on the previous cycle.
- ST_GRANT: a winner is being presented.

Transitions:
- ST_IDLE→ST_GRANT: some request qualifies.
- ST_GRANT→ST_IDLE: none does.
- ST_IDLE→ST_IDLE and ST_GRANT→ST_GRANT: the same condition holds as on the previous cycle.

Top module: `ila_arbiter`

## Requirements
- R1: After reset, all three level registers hold 0xFF, so every source is at code 11. `irq_accept`, `irq_src`, `irq_level` and `bus_rdata` are all zero.
- R2: Source n's code lives at bus address 0x7C + n/4, in bits [2(n mod 4)+1 : 2(n mod 4)]. A write takes effect at the clock edge where `bus_wr` is high.
- R3: Codes decode to levels as follows: 00 and 01 give level 1, 10 gives level 2, and 11 gives level 3. `irq_level` reports the decoded level (1 = 2'b01, 2 = 2'b10).
- R4: A source at code 11 (level 3) is never accepted, whatever `cpu_level` is.
- R5: A request is accepted only if its decoded level is strictly less than the CPU's effective level. The effective level equals `cpu_level`, except that a `cpu_level` of 00 counts as 1. So `cpu_level` 00 or 01 blocks every source, 10 passes only level 1, and 11 passes levels 1 and 2.
- R6: When several requests qualify, the one with the lowest decoded level wins. Among equal levels, the lowest-numbered source wins. `irq_src` gives the winner's number in binary.
- R7: The outputs reflect `irq_req`, `cpu_level` and the register contents one clock edge later. When nothing qualifies, `irq_accept`, `irq_src` and `irq_level` are all zero.
- R8: A write to any address outside 0x7C..0x7E changes no level code.
- R9: `bus_rdata` is registered. When `bus_rd` is high at an edge, it becomes 0xFF after that edge if the address is 0x7C..0x7E, and 0x00 otherwise. When `bus_rd` is low, it is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_req | input | 12 | Peripheral request lines, bit n is source n |
| cpu_level | input | 2 | Current CPU interrupt level |
| irq_accept | output | 1 | A qualified request is presented |
| irq_src | output | 4 | Winning source number |
| irq_level | output | 2 | Decoded level of the winner |

## Verification
The level registers cannot be read back, so a corrupted code only shows up at the ports through arbitration. It appears one edge after a request from that source is raised. The symptom is a missed accept, a spurious accept, a wrong winner or a wrong reported level. The bench therefore raises each source at several CPU levels after every write, and compares every cycle against a model of the register contents. A stuck output state is exposed on the first cycle where the qualification changes.

// File: rtl/ila_pkg.sv
package ila_pkg;

    localparam int LVL_W = 2;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_GRANT = 1'b1
    } arb_state_t;

    // code 00 and 01 both mean the top level
    function automatic lvl_t decode_level(lvl_t code);
        return (code == 2'b00) ? 2'b01 : code;
    endfunction

    // CPU level 00 is treated as level 1
    function automatic lvl_t cpu_effective(lvl_t cpu);
        return (cpu == 2'b00) ? 2'b01 : cpu;
    endfunction

endpackage

// File: rtl/ila_level_regs.sv
module ila_level_regs #(
    parameter int               NUM_SRC   = 12,
    parameter int               DATA_W    = 8,
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h7C
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic                        addr_hit,
    output logic [NUM_SRC*ila_pkg::LVL_W-1:0] codes
);
    import ila_pkg::*;

    localparam int FIELDS_PER_REG = DATA_W / LVL_W;
    localparam int NUM_REGS       = (NUM_SRC + FIELDS_PER_REG - 1) / FIELDS_PER_REG;

    logic [DATA_W-1:0]   regs [NUM_REGS];
    logic [NUM_REGS-1:0] reg_sel;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(BASE_ADDR) + r);

        assign reg_sel[r] = (bus_addr == MY_ADDR);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[r] <= '1;
            end else if (bus_wr && reg_sel[r]) begin
                regs[r] <= bus_wdata;
            end
        end
    end

    assign addr_hit = |reg_sel;

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_field
        localparam int REG_IDX = n / FIELDS_PER_REG;
        localparam int BIT_LO  = LVL_W * (n % FIELDS_PER_REG);
        assign codes[n*LVL_W +: LVL_W] = regs[REG_IDX][BIT_LO +: LVL_W];
    end

endmodule

// File: rtl/ila_qualify.sv
module ila_qualify #(
    parameter int NUM_SRC = 12
) (
    input  logic [NUM_SRC*ila_pkg::LVL_W-1:0] codes,
    input  logic [NUM_SRC-1:0]                req,
    input  ila_pkg::lvl_t                     cpu_level,
    output logic [NUM_SRC*ila_pkg::LVL_W-1:0] levels,
    output logic [NUM_SRC-1:0]                qual
);
    import ila_pkg::*;

    lvl_t cpu_eff;
    assign cpu_eff = cpu_effective(cpu_level);

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        lvl_t dec;
        assign dec = decode_level(codes[n*LVL_W +: LVL_W]);
        assign levels[n*LVL_W +: LVL_W] = dec;
        // level 3 can never be below the effective CPU level (max 3)
        assign qual[n] = req[n] && (dec < cpu_eff);
    end

endmodule

// File: rtl/ila_select.sv
module ila_select #(
    parameter int NUM_SRC = 12,
    parameter int SRC_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC*ila_pkg::LVL_W-1:0] levels,
    input  logic [NUM_SRC-1:0]                qual,
    output logic                              found,
    output logic [SRC_W-1:0]                  win_src,
    output ila_pkg::lvl_t                     win_level
);
    import ila_pkg::*;

    always_comb begin
        lvl_t cand;
        found     = 1'b0;
        win_src   = '0;
        win_level = '0;
        for (int n = 0; n < NUM_SRC; n++) begin
            cand = levels[n*LVL_W +: LVL_W];
            // strict compare keeps the lowest index on ties
            if (qual[n] && (!found || cand < win_level)) begin
                found     = 1'b1;
                win_src   = SRC_W'(n);
                win_level = cand;
            end
        end
    end

endmodule

// File: rtl/ila_arbiter.sv
module ila_arbiter #(
    parameter int                NUM_SRC   = 12,
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h7C,
    parameter int                SRC_W     = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [1:0]         cpu_level,
    output logic               irq_accept,
    output logic [SRC_W-1:0]   irq_src,
    output logic [1:0]         irq_level
);
    import ila_pkg::*;

    localparam int CODE_W = NUM_SRC * LVL_W;

    logic [CODE_W-1:0]  codes;
    logic [CODE_W-1:0]  levels;
    logic [NUM_SRC-1:0] qual;
    logic               addr_hit;
    logic               found;
    logic [SRC_W-1:0]   win_src;
    lvl_t               win_level;

    arb_state_t state_q, state_d;

    ila_level_regs #(
        .NUM_SRC  (NUM_SRC),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .BASE_ADDR(BASE_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .addr_hit (addr_hit),
        .codes    (codes)
    );

    ila_qualify #(
        .NUM_SRC(NUM_SRC)
    ) u_qual (
        .codes    (codes),
        .req      (irq_req),
        .cpu_level(cpu_level),
        .levels   (levels),
        .qual     (qual)
    );

    ila_select #(
        .NUM_SRC(NUM_SRC),
        .SRC_W  (SRC_W)
    ) u_sel (
        .levels   (levels),
        .qual     (qual),
        .found    (found),
        .win_src  (win_src),
        .win_level(win_level)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (found)  state_d = ST_GRANT;
            ST_GRANT: if (!found) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_src   <= '0;
            irq_level <= '0;
            bus_rdata <= '0;
        end else begin
            unique case (state_d)
                ST_GRANT: begin
                    irq_src   <= win_src;
                    irq_level <= win_level;
                end
                default: begin
                    irq_src   <= '0;
                    irq_level <= '0;
                end
            endcase
            bus_rdata <= (bus_rd && addr_hit) ? '1 : '0;
        end
    end

    assign irq_accept = (state_q == ST_GRANT);

endmodule

// File: rtl/ila_arbiter_chk.sv
module ila_arbiter_chk #(
    parameter int                NUM_SRC   = 12,
    parameter int                DATA_W    = 8,
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h7C,
    parameter int                SRC_W     = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_rd,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_SRC-1:0] irq_req,
    input logic [1:0]         cpu_level,
    input logic               irq_accept,
    input logic [SRC_W-1:0]   irq_src,
    input logic [1:0]         irq_level
);
    logic [NUM_SRC-1:0] past_req;
    logic [1:0]         past_eff;
    logic               rd_hit;

    assign rd_hit = bus_rd && (bus_addr >= BASE_ADDR) &&
                    (int'(bus_addr) < int'(BASE_ADDR) + 3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_req <= '0;
            past_eff <= 2'b11;
        end else begin
            past_req <= irq_req;
            past_eff <= (cpu_level == 2'b00) ? 2'b01 : cpu_level;
        end
    end

    // R7: idle outputs are all zero
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_accept |-> (irq_src == '0 && irq_level == 2'b00));

    // R7: no request, no accept on the next cycle
    a_r7_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req == '0) |=> !irq_accept);

    // R4: a granted level is never level 3
    a_r4_no_level3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |-> (irq_level == 2'b01 || irq_level == 2'b10));

    // R5: granted level is below the effective CPU level
    a_r5_outranks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |-> (irq_level < past_eff));

    // R6: the winner was actually requesting
    a_r6_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |-> (int'(irq_src) < NUM_SRC && past_req[irq_src]));

    // R9: a read of a level address returns all ones
    a_r9_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> (bus_rdata == '1));

    // R9: no read, zero read data
    a_r9_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

endmodule

bind ila_arbiter ila_arbiter_chk #(
    .NUM_SRC  (NUM_SRC),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .SRC_W    (SRC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req),
    .cpu_level (cpu_level),
    .irq_accept(irq_accept),
    .irq_src   (irq_src),
    .irq_level (irq_level)
);

// File: tb/test_ila_arbiter.sv
module test_ila_arbiter;

    typedef struct {
        logic       acc;
        logic [3:0] src;
        logic [1:0] lvl;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [11:0] irq_req = '0;
    logic [1:0]  cpu_level = 2'b11;
    logic        irq_accept;
    logic [3:0]  irq_src;
    logic [1:0]  irq_level;

    int checks = 0;
    int errors = 0;
    logic [1:0] model_code [12];
    exp_t sb_q [$];

    always #5 clk = ~clk;

    ila_arbiter i_ila_arbiter (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req   (irq_req),
        .cpu_level (cpu_level),
        .irq_accept(irq_accept),
        .irq_src   (irq_src),
        .irq_level (irq_level)
    );

    function automatic exp_t predict(logic [11:0] req, logic [1:0] cpu, string tag);
        exp_t e;
        logic [1:0] eff;
        logic [1:0] d;
        eff = (cpu == 2'b00) ? 2'b01 : cpu;
        e.acc = 1'b0; e.src = 4'd0; e.lvl = 2'd0; e.tag = tag;
        for (int n = 0; n < 12; n++) begin
            d = (model_code[n] == 2'b00) ? 2'b01 : model_code[n];
            if (req[n] && d < eff && (!e.acc || d < e.lvl)) begin
                e.acc = 1'b1; e.src = 4'(n); e.lvl = d;
            end
        end
        return e;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] addr, logic [7:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        if (addr >= 8'h7C && addr <= 8'h7E)
            for (int k = 0; k < 4; k++)
                model_code[(int'(addr) - 'h7C) * 4 + k] = data[2*k +: 2];
    endtask

    task automatic bus_read(logic [7:0] addr, logic [7:0] exp, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = addr;
        @(posedge clk);
        #1;
        check(tag, {8'h00, bus_rdata}, {8'h00, exp});
        bus_rd = 1'b0;
    endtask

    // driver: apply stimulus and push the expected result
    task automatic apply(logic [11:0] req, logic [1:0] cpu, string tag);
        @(negedge clk);
        irq_req = req; cpu_level = cpu;
        sb_q.push_back(predict(req, cpu, tag));
    endtask

    // monitor: compare one edge after the stimulus (R7 timing)
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                check(e.tag, {12'h000, 1'b0, irq_accept, irq_level},
                             {12'h000, 1'b0, e.acc, e.lvl});
                check({e.tag, " src"}, {12'h000, irq_src}, {12'h000, e.src});
            end
        end
    end

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int n = 0; n < 12; n++) model_code[n] = 2'b11;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset accept", {15'h0, irq_accept}, 16'h0);
        check("R1 reset src", {12'h0, irq_src}, 16'h0);
        check("R1 reset level", {14'h0, irq_level}, 16'h0);
        check("R1 reset rdata", {8'h0, bus_rdata}, 16'h0);
        @(negedge clk);
        rst_n = 1'b1;

        apply(12'hFFF, 2'b11, "R1 all sources level3 after reset");

        // s0=00 s1=01 s2=10 s3=11
        bus_write(8'h7C, 8'b11_10_01_00);
        apply(12'h008, 2'b11, "R4 code11 rejected");
        apply(12'h004, 2'b11, "R3 code10 is level2");
        apply(12'h002, 2'b11, "R3 code01 is level1");
        apply(12'h001, 2'b11, "R3 code00 is level1");
        apply(12'h003, 2'b11, "R6 tie lowest index");
        apply(12'h006, 2'b11, "R6 higher level wins");
        apply(12'h00C, 2'b11, "R4 level3 loses to level2");
        apply(12'h004, 2'b10, "R5 level2 blocked at cpu2");
        apply(12'h006, 2'b10, "R5 level1 passes cpu2");
        apply(12'h001, 2'b01, "R5 cpu1 blocks all");
        apply(12'h003, 2'b00, "R5 cpu0 treated as 1");
        apply(12'h000, 2'b11, "R7 no request zero");
        apply(12'h008, 2'b00, "R4 level3 at cpu0");

        // s7=10 in second byte, s9=01 in third byte
        bus_write(8'h7D, 8'b10_11_11_11);
        bus_write(8'h7E, 8'b11_11_01_11);
        apply(12'h280, 2'b11, "R2 third byte field wins");
        apply(12'h084, 2'b11, "R6 level2 tie s2 over s7");
        apply(12'h080, 2'b11, "R2 second byte top field");
        apply(12'h100, 2'b11, "R2 neighbour s8 still level3");

        // writes outside the block
        bus_write(8'h7B, 8'h00);
        bus_write(8'h7F, 8'h00);
        bus_write(8'h00, 8'h00);
        apply(12'hD08, 2'b11, "R8 outside writes ignored");
        apply(12'h004, 2'b11, "R8 s2 unchanged");

        bus_read(8'h7C, 8'hFF, "R9 read 0x7C ones");
        bus_read(8'h7E, 8'hFF, "R9 read 0x7E ones");
        bus_read(8'h7F, 8'h00, "R9 read outside zero");
        bus_read(8'h10, 8'h00, "R9 read far zero");

        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 7) == 0)
                bus_write(8'h7C + 8'($urandom_range(0, 2)), 8'($urandom()));
            apply(12'($urandom()), 2'($urandom()), "R6 random arbitration");
        end

        apply(12'h000, 2'b11, "R7 final idle");
        repeat (3) @(posedge clk);
        #1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule